// File: doc/BRIEF.md
# Banked Internal Data Memory

This block is the on-chip scratch memory of an 8-bit controller core. It holds 256 bytes of RAM and fronts a separate register space for peripherals that overlays the upper half of the address range. A byte access carries an addressing mode. A direct access to the upper half reaches a peripheral register over the register bus, while an indirect access to the same address reaches the upper half of RAM. A register-mode access names one of eight working registers, and the block places it in one of four banks at the bottom of RAM, using a bank-select input.

A separate bit port works on single bits. The lower half of the 8-bit bit address covers a 16-byte window of RAM just above the register banks. The upper half covers the peripheral registers whose address is a multiple of eight. Set, clear and write are read-modify-write operations on the containing byte, and each finishes in the clock cycle it is issued. The byte port and the bit port run in parallel, so a core can issue a byte access and a bit operation in the same cycle.

Top module: `idata_mem`

## Requirements
- R1: A byte access with mode 2'b00 (direct) to addresses 0x00–0x7F, or with mode 2'b01 (indirect) or 2'b11 to any address, reads or writes RAM. Write data is stored at the clock edge. Read data appears on `b_rdata_o` one cycle after `b_rd_i` and then holds until the next read.
- R2: A direct byte access to 0x80–0xFF goes to the register bus in the same cycle. `sfr_addr_o` equals the byte address, `sfr_rd_o` or `sfr_wr_o` is raised, and RAM is not written.
- R3: An indirect byte access to 0x80–0xFF uses the upper 128 bytes of RAM and raises no register-bus strobe.
- R4: A byte access with mode 2'b10 (register) reaches RAM address 8*`bank_i` + `b_addr_i[2:0]`. Address bits 7:3 are ignored.
- R5: Bit addresses 0x00–0x7F select RAM byte 0x20 + (address >> 3), at bit position address[2:0].
- R6: Bit addresses 0x80–0xFF select register byte (address & 0xF8), at bit position address[2:0], over the register bus.
- R7: Bit operation codes are 0 read, 1 set, 2 clear and 3 write-`bit_wdata_i`. Only the addressed bit of the byte changes, and the new byte is stored at the same clock edge. One cycle after the operation, `bit_rdata_o` carries the bit's value from before the operation.
- R8: When `sfr_present_i` is low for the address on the bus, a read returns 0x00 and `sfr_wr_o` stays low, for both byte and bit operations.
- R9: A byte access and a bit operation in the same cycle on different RAM bytes both take effect. A byte read of the byte that a bit operation changes in the same cycle returns the old value.
- R10: When a byte-port register access and a bit-port register operation fall in the same cycle, the byte port owns the bus. The bit operation changes nothing, and its `bit_rdata_o` is 0.
- R11: After reset, `b_rdata_o` and `bit_rdata_o` are 0. With no request, neither register strobe is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| b_mode_i | input | 2 | Byte addressing mode: 00 direct, 01 indirect, 10 register, 11 indirect |
| b_addr_i | input | 8 | Byte address, or register index in bits 2:0 |
| bank_i | input | 2 | Register bank select |
| b_rd_i | input | 1 | Byte read strobe |
| b_wr_i | input | 1 | Byte write strobe |
| b_wdata_i | input | 8 | Byte write data |
| b_rdata_o | output | 8 | Byte read data, one cycle after the read |
| bit_req_i | input | 1 | Bit operation request |
| bit_addr_i | input | 8 | Bit address |
| bit_op_i | input | 2 | Bit operation code |
| bit_wdata_i | input | 1 | Value for the write operation |
| bit_rdata_o | output | 1 | Bit value before the last operation |
| sfr_addr_o | output | 8 | Register bus address |
| sfr_wdata_o | output | 8 | Register bus write data |
| sfr_rd_o | output | 1 | Register bus read strobe |
| sfr_wr_o | output | 1 | Register bus write strobe |
| sfr_rdata_i | input | 8 | Register bus read data, combinational from the peripheral |
| sfr_present_i | input | 1 | A register exists at `sfr_addr_o` |

## Verification
The byte port and the bit port can act in the same cycle, and the outcome depends on which resources they share. The bench drives both ports at one falling edge: a byte write and a bit set on different RAM bytes, a byte read of the very byte a bit set rewrites, and a direct register write alongside a bit set on another register. It then judges the result by reading back through the byte port and by the contents of its own register-bus model. The expected outcome is that both RAM updates land, the same-cycle read returns the old byte, and the bit operation that lost the bus leaves its register untouched and reports 0.

// File: rtl/idm_pkg.sv
package idm_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned POS_W  = $clog2(BYTE_W);

  typedef enum logic [1:0] {
    MODE_DIRECT   = 2'd0,
    MODE_INDIRECT = 2'd1,
    MODE_REG      = 2'd2,
    MODE_ALT_IND  = 2'd3
  } acc_mode_e;

  typedef enum logic [1:0] {
    BOP_READ  = 2'd0,
    BOP_SET   = 2'd1,
    BOP_CLR   = 2'd2,
    BOP_WRITE = 2'd3
  } bit_op_e;

  // Apply a single-bit operation to a byte; only position p may change.
  function automatic logic [BYTE_W-1:0] bit_apply(
    input logic [BYTE_W-1:0] b,
    input logic [POS_W-1:0]  p,
    input bit_op_e           op,
    input logic              v
  );
    logic [BYTE_W-1:0] r;
    r = b;
    case (op)
      BOP_SET:   r[p] = 1'b1;
      BOP_CLR:   r[p] = 1'b0;
      BOP_WRITE: r[p] = v;
      default:   r = b;
    endcase
    return r;
  endfunction

  function automatic logic op_modifies(input bit_op_e op);
    return op != BOP_READ;
  endfunction
endpackage

// File: rtl/idm_byte_decode.sv
module idm_byte_decode
  import idm_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned BANK_W = 2,
  parameter int unsigned IDX_W  = 3
) (
  input  logic [1:0]        mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BANK_W-1:0] bank_i,
  output logic [ADDR_W-1:0] phys_o,
  output logic              to_sfr_o
);
  localparam int unsigned PAD_W = ADDR_W - BANK_W - IDX_W;

  acc_mode_e mode;
  assign mode = acc_mode_e'(mode_i);

  // Register slot: bank number above the index, zero above that.
  function automatic logic [ADDR_W-1:0] reg_slot(
    input logic [BANK_W-1:0] bank,
    input logic [IDX_W-1:0]  idx
  );
    return {{PAD_W{1'b0}}, bank, idx};
  endfunction

  always_comb begin
    to_sfr_o = (mode == MODE_DIRECT) && addr_i[ADDR_W-1];
    if (mode == MODE_REG) phys_o = reg_slot(bank_i, addr_i[IDX_W-1:0]);
    else                  phys_o = addr_i;
  end
endmodule

// File: rtl/idm_bit_decode.sv
module idm_bit_decode
  import idm_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter logic [7:0]  BIT_BASE = 8'h20
) (
  input  logic [ADDR_W-1:0] bit_addr_i,
  output logic [ADDR_W-1:0] byte_addr_o,
  output logic [POS_W-1:0]  pos_o,
  output logic              is_sfr_o
);
  localparam int unsigned IDX_W = ADDR_W - 1 - POS_W;

  function automatic logic [ADDR_W-1:0] ram_window(input logic [IDX_W-1:0] idx);
    return ADDR_W'(BIT_BASE) + {{(ADDR_W-IDX_W){1'b0}}, idx};
  endfunction

  function automatic logic [ADDR_W-1:0] sfr_aligned(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:POS_W], {POS_W{1'b0}}};
  endfunction

  always_comb begin
    is_sfr_o = bit_addr_i[ADDR_W-1];
    pos_o    = bit_addr_i[POS_W-1:0];
    if (is_sfr_o) byte_addr_o = sfr_aligned(bit_addr_i);
    else          byte_addr_o = ram_window(bit_addr_i[ADDR_W-2:POS_W]);
  end
endmodule

// File: rtl/idm_bit_alu.sv
module idm_bit_alu
  import idm_pkg::*;
(
  input  logic [BYTE_W-1:0] old_i,
  input  logic [POS_W-1:0]  pos_i,
  input  logic [1:0]        op_i,
  input  logic              val_i,
  output logic [BYTE_W-1:0] new_o,
  output logic              old_bit_o,
  output logic              modifies_o
);
  bit_op_e op;
  assign op         = bit_op_e'(op_i);
  assign new_o      = bit_apply(old_i, pos_i, op, val_i);
  assign old_bit_o  = old_i[pos_i];
  assign modifies_o = op_modifies(op);
endmodule

// File: rtl/idm_ram.sv
module idm_ram #(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned WIDTH = 8,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             a_we_i,
  input  logic [AW-1:0]    a_addr_i,
  input  logic [WIDTH-1:0] a_wdata_i,
  input  logic             rd_en_i,
  input  logic [AW-1:0]    rd_addr_i,
  output logic [WIDTH-1:0] rd_data_o,
  input  logic [AW-1:0]    pk_addr_i,
  output logic [WIDTH-1:0] pk_data_o,
  input  logic             b_we_i,
  input  logic [AW-1:0]    b_addr_i,
  input  logic [WIDTH-1:0] b_wdata_i
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (a_we_i) mem[a_addr_i] <= a_wdata_i;
    if (b_we_i) mem[b_addr_i] <= b_wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rd_data_o <= '0;
    else if (rd_en_i) rd_data_o <= mem[rd_addr_i];
  end

  assign pk_data_o = mem[pk_addr_i];

  // R9: the two write ports never aim at one byte in the same cycle
  dual_write_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_we_i && b_we_i) |-> (a_addr_i != b_addr_i));
endmodule

// File: rtl/idata_mem.sv
module idata_mem
  import idm_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned BANK_W   = 2,
  parameter int unsigned IDX_W    = 3,
  parameter logic [7:0]  BIT_BASE = 8'h20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        b_mode_i,
  input  logic [ADDR_W-1:0] b_addr_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic              b_rd_i,
  input  logic              b_wr_i,
  input  logic [BYTE_W-1:0] b_wdata_i,
  output logic [BYTE_W-1:0] b_rdata_o,
  input  logic              bit_req_i,
  input  logic [ADDR_W-1:0] bit_addr_i,
  input  logic [1:0]        bit_op_i,
  input  logic              bit_wdata_i,
  output logic              bit_rdata_o,
  output logic [ADDR_W-1:0] sfr_addr_o,
  output logic [BYTE_W-1:0] sfr_wdata_o,
  output logic              sfr_rd_o,
  output logic              sfr_wr_o,
  input  logic [BYTE_W-1:0] sfr_rdata_i,
  input  logic              sfr_present_i
);
  localparam int unsigned DEPTH     = 1 << ADDR_W;
  localparam int unsigned BANK_SPAN = (1 << BANK_W) * (1 << IDX_W);
  localparam int unsigned BIT_BYTES = (1 << (ADDR_W - 1)) / BYTE_W;

  // ---------------- byte port decode ----------------
  logic [ADDR_W-1:0] b_phys;
  logic              b_is_sfr;
  logic              byte_req, byte_sfr, byte_ram_wr, byte_ram_rd;

  idm_byte_decode #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .IDX_W(IDX_W)) u_bdec (
    .mode_i  (b_mode_i),
    .addr_i  (b_addr_i),
    .bank_i  (bank_i),
    .phys_o  (b_phys),
    .to_sfr_o(b_is_sfr)
  );

  assign byte_req    = b_rd_i | b_wr_i;
  assign byte_sfr    = byte_req & b_is_sfr;
  assign byte_ram_wr = b_wr_i & ~b_is_sfr;
  assign byte_ram_rd = b_rd_i & ~b_is_sfr;

  // ---------------- bit port decode ----------------
  logic [ADDR_W-1:0] bit_byte;
  logic [POS_W-1:0]  bit_pos;
  logic              bit_is_sfr;
  logic              bit_sfr_req, bit_dropped, bit_sfr_go, bit_ram_go;

  idm_bit_decode #(.ADDR_W(ADDR_W), .BIT_BASE(BIT_BASE)) u_xdec (
    .bit_addr_i (bit_addr_i),
    .byte_addr_o(bit_byte),
    .pos_o      (bit_pos),
    .is_sfr_o   (bit_is_sfr)
  );

  assign bit_sfr_req = bit_req_i & bit_is_sfr;
  assign bit_dropped = bit_sfr_req & byte_sfr;   // byte port owns the bus
  assign bit_sfr_go  = bit_sfr_req & ~byte_sfr;
  assign bit_ram_go  = bit_req_i & ~bit_is_sfr;

  // ---------------- register bus ----------------
  logic [BYTE_W-1:0] sfr_rd_safe;
  logic [BYTE_W-1:0] bit_old, bit_new, ram_peek;
  logic              bit_old_bit, bit_mod;

  assign sfr_rd_safe = sfr_present_i ? sfr_rdata_i : '0;

  always_comb begin
    if (byte_sfr) begin
      sfr_addr_o  = b_addr_i;
      sfr_wdata_o = b_wdata_i;
      sfr_rd_o    = b_rd_i;
      sfr_wr_o    = b_wr_i & sfr_present_i;
    end else if (bit_sfr_go) begin
      sfr_addr_o  = bit_byte;
      sfr_wdata_o = bit_new;
      sfr_rd_o    = 1'b1;
      sfr_wr_o    = bit_mod & sfr_present_i;
    end else begin
      sfr_addr_o  = '0;
      sfr_wdata_o = '0;
      sfr_rd_o    = 1'b0;
      sfr_wr_o    = 1'b0;
    end
  end

  // ---------------- bit read-modify-write ----------------
  assign bit_old = bit_is_sfr ? sfr_rd_safe : ram_peek;

  idm_bit_alu u_alu (
    .old_i     (bit_old),
    .pos_i     (bit_pos),
    .op_i      (bit_op_i),
    .val_i     (bit_wdata_i),
    .new_o     (bit_new),
    .old_bit_o (bit_old_bit),
    .modifies_o(bit_mod)
  );

  // ---------------- RAM ----------------
  logic [BYTE_W-1:0] ram_rdata;

  idm_ram #(.DEPTH(DEPTH), .WIDTH(BYTE_W)) u_ram (
    .clk      (clk),
    .rst_n    (rst_n),
    .a_we_i   (byte_ram_wr),
    .a_addr_i (b_phys),
    .a_wdata_i(b_wdata_i),
    .rd_en_i  (byte_ram_rd),
    .rd_addr_i(b_phys),
    .rd_data_o(ram_rdata),
    .pk_addr_i(bit_byte),
    .pk_data_o(ram_peek),
    .b_we_i   (bit_ram_go & bit_mod),
    .b_addr_i (bit_byte),
    .b_wdata_i(bit_new)
  );

  // ---------------- read-data registers ----------------
  logic              rd_from_sfr_q;
  logic [BYTE_W-1:0] sfr_q;
  logic              bit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_from_sfr_q <= 1'b0;
      sfr_q         <= '0;
      bit_q         <= 1'b0;
    end else begin
      if (b_rd_i) begin
        rd_from_sfr_q <= b_is_sfr;
        if (b_is_sfr) sfr_q <= sfr_rd_safe;
      end
      if (bit_req_i) bit_q <= bit_dropped ? 1'b0 : bit_old_bit;
    end
  end

  assign b_rdata_o   = rd_from_sfr_q ? sfr_q : ram_rdata;
  assign bit_rdata_o = bit_q;

  // ---------------- assertions ----------------
  // R2
  sfr_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_sfr |-> (sfr_addr_o == b_addr_i) && (sfr_rd_o == b_rd_i) && !byte_ram_wr);

  // R3
  indirect_no_sfr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_req && b_mode_i == MODE_INDIRECT && !bit_sfr_req) |-> !sfr_rd_o && !sfr_wr_o);

  // R4
  reg_bank_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_req && b_mode_i == MODE_REG) |-> (b_phys < ADDR_W'(BANK_SPAN)));

  // R5
  bit_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_req_i && !bit_addr_i[ADDR_W-1]) |->
      (bit_byte >= ADDR_W'(BIT_BASE)) && (bit_byte < ADDR_W'(BIT_BASE) + ADDR_W'(BIT_BYTES)));

  // R7
  bit_one_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_req_i && !bit_dropped) |-> ($countones(bit_old ^ bit_new) <= 1));

  // R8
  absent_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (b_rd_i && b_is_sfr && !sfr_present_i) |=> (b_rdata_o == '0));

  // R8
  absent_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sfr_present_i |-> !sfr_wr_o);

  // R10
  bit_yield_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_dropped |=> (bit_rdata_o == 1'b0));

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!byte_req && !bit_req_i) |-> !sfr_rd_o && !sfr_wr_o);
endmodule

// File: tb/sim_idata_mem.sv
module sim_idata_mem;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] b_mode = 2'd0;
  logic [7:0] b_addr = '0;
  logic [1:0] bank = '0;
  logic       b_rd = 1'b0, b_wr = 1'b0;
  logic [7:0] b_wdata = '0;
  logic [7:0] b_rdata;
  logic       bit_req = 1'b0;
  logic [7:0] bit_addr = '0;
  logic [1:0] bit_op = '0;
  logic       bit_wdata = 1'b0;
  logic       bit_rdata;
  logic [7:0] sfr_addr, sfr_wdata, sfr_rdata;
  logic       sfr_rd, sfr_wr, sfr_present;

  int checks = 0;
  int errors = 0;
  int sfr_wr_count = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  idata_mem u0 (
    .clk(clk), .rst_n(rst_n),
    .b_mode_i(b_mode), .b_addr_i(b_addr), .bank_i(bank),
    .b_rd_i(b_rd), .b_wr_i(b_wr), .b_wdata_i(b_wdata), .b_rdata_o(b_rdata),
    .bit_req_i(bit_req), .bit_addr_i(bit_addr), .bit_op_i(bit_op),
    .bit_wdata_i(bit_wdata), .bit_rdata_o(bit_rdata),
    .sfr_addr_o(sfr_addr), .sfr_wdata_o(sfr_wdata), .sfr_rd_o(sfr_rd),
    .sfr_wr_o(sfr_wr), .sfr_rdata_i(sfr_rdata), .sfr_present_i(sfr_present)
  );

  // Peripheral register model
  logic [7:0] regs [256];
  function automatic logic exists(input logic [7:0] a);
    return a == 8'h80 || a == 8'h88 || a == 8'h90 || a == 8'hE0 || a == 8'hF0 || a == 8'hB3;
  endfunction
  assign sfr_present = exists(sfr_addr);
  assign sfr_rdata   = exists(sfr_addr) ? regs[sfr_addr] : 8'hA5;
  always @(posedge clk) begin
    if (sfr_wr) begin
      regs[sfr_addr] <= sfr_wdata;
      sfr_wr_count   <= sfr_wr_count + 1;
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bwrite(input logic [1:0] m, input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); b_mode = m; b_addr = a; b_wdata = d; b_wr = 1'b1;
    @(posedge clk); #1; b_wr = 1'b0;
  endtask

  task automatic bread(input logic [1:0] m, input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); b_mode = m; b_addr = a; b_rd = 1'b1;
    @(posedge clk); #1; b_rd = 1'b0; d = b_rdata;
  endtask

  task automatic bitop(input logic [7:0] a, input logic [1:0] op, input logic v, output logic old);
    @(negedge clk); bit_addr = a; bit_op = op; bit_wdata = v; bit_req = 1'b1;
    @(posedge clk); #1; bit_req = 1'b0; old = bit_rdata;
  endtask

  task automatic t_reset();
    chk("R11 b_rdata after reset", b_rdata, 8'h00);
    chk("R11 bit_rdata after reset", {7'd0, bit_rdata}, 8'h00);
    chk("R11 idle strobes", {6'd0, sfr_rd, sfr_wr}, 8'h00);
  endtask

  task automatic t_ram_modes();
    logic [7:0] d;
    int n0;
    bwrite(2'd1, 8'h10, 8'h77);
    bread(2'd0, 8'h10, d);
    chk("R1 indirect low write, direct read", d, 8'h77);
    bwrite(2'd1, 8'h90, 8'h5A);
    n0 = sfr_wr_count;
    @(negedge clk); b_mode = 2'd1; b_addr = 8'h90; b_wr = 1'b1; b_wdata = 8'h5B; #1;
    chk("R3 indirect upper raises no strobe", {6'd0, sfr_rd, sfr_wr}, 8'h00);
    @(posedge clk); #1; b_wr = 1'b0;
    chk("R3 no register write count", 8'(sfr_wr_count - n0), 8'h00);
    bwrite(2'd0, 8'h90, 8'h33);
    chk("R2 direct upper write lands in register", regs[8'h90], 8'h33);
    bread(2'd1, 8'h90, d);
    chk("R3 indirect upper RAM kept", d, 8'h5B);
    bread(2'd0, 8'h90, d);
    chk("R2 direct upper read from register", d, 8'h33);
    bread(2'd3, 8'h90, d);
    chk("R1 mode 3 behaves as indirect", d, 8'h5B);
  endtask

  task automatic t_banks();
    logic [7:0] d;
    for (int b = 0; b < 4; b++) begin
      bank = 2'(b);
      bwrite(2'd2, 8'hFD, 8'(8'h10 + b));
    end
    for (int b = 0; b < 4; b++) begin
      bread(2'd0, 8'(8 * b + 5), d);
      chk("R4 bank register maps to 8*bank+n", d, 8'(8'h10 + b));
    end
    bank = 2'd2;
    bread(2'd2, 8'h05, d);
    chk("R4 register-mode read bank 2", d, 8'h12);
  endtask

  task automatic t_bit_ram();
    logic [7:0] d;
    logic o;
    bwrite(2'd0, 8'h2F, 8'h00);
    bwrite(2'd0, 8'h20, 8'hFF);
    bitop(8'h7F, 2'd1, 1'b0, o);
    chk("R7 set returns old bit", {7'd0, o}, 8'h00);
    bitop(8'h79, 2'd1, 1'b0, o);
    bread(2'd0, 8'h2F, d);
    chk("R5 bit 0x7F/0x79 map to byte 0x2F", d, 8'h82);
    bitop(8'h00, 2'd2, 1'b0, o);
    chk("R7 clear returns old bit 1", {7'd0, o}, 8'h01);
    bitop(8'h05, 2'd3, 1'b0, o);
    bread(2'd0, 8'h20, d);
    chk("R5 bits 0x00/0x05 only change in byte 0x20", d, 8'hDE);
    bitop(8'h7F, 2'd0, 1'b0, o);
    chk("R7 bit read", {7'd0, o}, 8'h01);
    bitop(8'h05, 2'd0, 1'b0, o);
    chk("R7 bit read after write 0", {7'd0, o}, 8'h00);
  endtask

  task automatic t_bit_sfr();
    logic [7:0] d;
    logic o;
    int n0;
    bwrite(2'd0, 8'hE0, 8'h0F);
    bitop(8'hE7, 2'd1, 1'b0, o);
    chk("R6 set bit 0xE7 -> reg 0xE0", regs[8'hE0], 8'h8F);
    bitop(8'hE1, 2'd2, 1'b0, o);
    bitop(8'hE4, 2'd3, 1'b1, o);
    bread(2'd0, 8'hE0, d);
    chk("R6 clear/write on reg 0xE0", d, 8'h9D);
    bitop(8'hE4, 2'd0, 1'b0, o);
    chk("R6 bit read from register", {7'd0, o}, 8'h01);
    n0 = sfr_wr_count;
    bitop(8'hB3, 2'd1, 1'b0, o);
    chk("R8 bit set on absent 0xB0 no write", 8'(sfr_wr_count - n0), 8'h00);
    bitop(8'hB3, 2'd0, 1'b0, o);
    chk("R8 bit read on absent is 0", {7'd0, o}, 8'h00);
  endtask

  task automatic t_absent();
    logic [7:0] d;
    int n0;
    bread(2'd0, 8'h85, d);
    chk("R8 absent register reads 0", d, 8'h00);
    n0 = sfr_wr_count;
    bwrite(2'd0, 8'h85, 8'hEE);
    chk("R8 absent register write suppressed", 8'(sfr_wr_count - n0), 8'h00);
  endtask

  task automatic t_same_cycle();
    logic [7:0] d;
    bwrite(2'd0, 8'h21, 8'h00);
    @(negedge clk);
    b_mode = 2'd0; b_addr = 8'h30; b_wdata = 8'h3C; b_wr = 1'b1;
    bit_addr = 8'h0A; bit_op = 2'd1; bit_req = 1'b1;
    @(posedge clk); #1; b_wr = 1'b0; bit_req = 1'b0;
    bread(2'd0, 8'h30, d);
    chk("R9 byte write in shared cycle", d, 8'h3C);
    bread(2'd0, 8'h21, d);
    chk("R9 bit set in shared cycle", d, 8'h04);
    @(negedge clk);
    b_mode = 2'd0; b_addr = 8'h21; b_rd = 1'b1;
    bit_addr = 8'h0B; bit_op = 2'd1; bit_req = 1'b1;
    @(posedge clk); #1; b_rd = 1'b0; bit_req = 1'b0;
    chk("R9 same-byte read sees old value", b_rdata, 8'h04);
    bread(2'd0, 8'h21, d);
    chk("R9 bit set landed", d, 8'h0C);
    @(negedge clk);
    b_mode = 2'd0; b_addr = 8'h80; b_wdata = 8'h11; b_wr = 1'b1;
    bit_addr = 8'h97; bit_op = 2'd1; bit_req = 1'b1;
    @(posedge clk); #1; b_wr = 1'b0; bit_req = 1'b0;
    chk("R10 bit op yields bit_rdata 0", {7'd0, bit_rdata}, 8'h00);
    chk("R10 byte write wins the bus", regs[8'h80], 8'h11);
    chk("R10 yielded bit op left reg 0x90", regs[8'h90], 8'h33);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) regs[i] = 8'h00;
    repeat (3) @(posedge clk);
    #1; t_reset();
    rst_n = 1'b1;
    t_ram_modes();
    t_banks();
    t_bit_ram();
    t_bit_sfr();
    t_absent();
    t_same_cycle();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule